// File: doc/BRIEF.md
# LPC Bus I/O and DMA Target

This block sits on the peripheral side of a Low Pin Count bus. It watches the four multiplexed LAD lines and the active-low frame strobe, recognises single-byte I/O reads and writes aimed at a programmable 2^AW-byte address window, and recognises single-byte DMA transfers on one configured channel. For each claimed cycle it answers with a turnaround, a train of wait SYNC nibbles, a completion SYNC, any read data, and a closing turnaround.

Toward the internal logic it offers a plain byte port. A one-clock strobe (`io_rd`, `io_wr`, `dma_put`, `dma_get`) marks the clock in which the transfer completes. Write data and the window offset are valid alongside the strobe, and read data is sampled in that same clock. A slow register file can hold `be_busy` to stretch the I/O wait phase, which is bounded by a timeout. `be_err` turns the completion into an error SYNC.

Top module: `lpc_io_dma_target`

## Requirements
- R1: A cycle starts only when `lframe_n` is sampled low with `lad_in` = 0000. A frame nibble of any other value is ignored. While `lframe_n` stays low, the last nibble seen with it low is the one that counts.
- R2: After any clock in which `lframe_n` is sampled low, `lad_oe` is 0 in the next clock and decoding restarts, so an interrupted cycle is abandoned.
- R3: The nibble after START selects the cycle: 0000 is an I/O read, 0010 an I/O write, 1000 a DMA read (host to peripheral) and 1010 a DMA write (peripheral to host). Any other value is ignored. I/O cycles carry four address nibbles, most significant first, and are claimed only when address bits [15:AW] equal `io_base[15:AW]`. DMA cycles carry a channel nibble and then a size nibble, and are claimed only when channel bits [2:0] equal DMA_CHAN and the size nibble is 0000.
- R4: The target drives its first SYNC nibble in the clock right after the two-clock host turnaround. Within one cycle it repeats a single wait code, and it ends the SYNC phase with 0000 when there is no error.
- R5: I/O cycles wait with 0110, for IO_RD_WAIT (3) clocks on reads and IO_WR_WAIT (2) on writes. DMA cycles wait with 0101, for DMA_RD_WAIT (3) clocks on reads and DMA_WR_WAIT (4) on writes. `be_busy` has no effect on DMA cycles.
- R6: On I/O cycles, `be_busy` holds the wait phase open past the fixed count. After LONG_WAIT wait clocks the target completes on its own with 1010, raises no strobe, and returns FFh on a read.
- R7: `be_err`, sampled in the completing clock, turns the completion nibble into 1010. The strobe still fires, and on reads both data nibbles are still driven.
- R8: While `rst_n` is low, `lad_oe` is 0, no strobe fires and `lframe_n` is ignored.
- R9: Data bytes travel low nibble first in both directions. The strobe is high only in the completion clock, with `acc_addr` and `wr_data` valid. `rd_data` is sampled in that clock.
- R10: After its last SYNC or data nibble, the target drives 1111 for one clock and releases LAD in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset |
| lframe_n | input | 1 | Active-low frame strobe |
| lad_in | input | 4 | LAD value seen on the bus |
| lad_out | output | 4 | LAD value driven by the target |
| lad_oe | output | 1 | High while the target drives LAD |
| io_base | input | 16 | I/O window base; bits [AW-1:0] are ignored |
| acc_addr | output | AW | Offset of the I/O access inside the window |
| wr_data | output | 8 | Byte received from the host |
| rd_data | input | 8 | Byte to return to the host |
| io_rd | output | 1 | I/O read completes this clock |
| io_wr | output | 1 | I/O write completes this clock |
| dma_put | output | 1 | DMA byte toward the peripheral completes this clock |
| dma_get | output | 1 | DMA byte from the peripheral completes this clock |
| be_busy | input | 1 | Back end not ready; extends I/O waits |
| be_err | input | 1 | Back end reports an error on this transfer |

## Verification
The bench builds the block with AW = 4, DMA_CHAN = 3 and LONG_WAIT = 12, with `io_base` at 02E0h. Shrinking the timeout from 330 to 12 clocks brings the self-completing timeout path within a short run, both exactly at the limit and past it. The non-zero channel and the narrow window make it possible to test a near-miss address, a wrong channel, and a channel nibble with its top bit set.

// File: rtl/lpc_io_dma_target.sv
module lpc_io_dma_target #(
  parameter int AW          = 4,
  parameter int DMA_CHAN    = 2,
  parameter int IO_RD_WAIT  = 3,
  parameter int IO_WR_WAIT  = 2,
  parameter int DMA_RD_WAIT = 3,
  parameter int DMA_WR_WAIT = 4,
  parameter int LONG_WAIT   = 330
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lframe_n,
  input  logic [3:0]    lad_in,
  output logic [3:0]    lad_out,
  output logic          lad_oe,
  input  logic [15:0]   io_base,
  output logic [AW-1:0] acc_addr,
  output logic [7:0]    wr_data,
  input  logic [7:0]    rd_data,
  output logic          io_rd,
  output logic          io_wr,
  output logic          dma_put,
  output logic          dma_get,
  input  logic          be_busy,
  input  logic          be_err
);
  localparam int WW = $clog2(LONG_WAIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CT, S_ADR, S_CH, S_SZ, S_HDAT, S_HTAR, S_SYNC, S_TDAT, S_TTAR
  } st_t;
  typedef enum logic [1:0] {C_IORD, C_IOWR, C_DMARD, C_DMAWR} cls_t;

  st_t           st;
  cls_t          cls;
  logic [1:0]    cnt;
  logic [15:0]   adr;
  logic [7:0]    dat;
  logic [WW-1:0] wcnt;

  logic          is_dma, host_data, busy_eff, timeout, ready, fire, hit, in_sync;
  logic [WW-1:0] fix_wait;
  logic [15:0]   adr_next;
  logic [3:0]    sync_nib;

  assign is_dma    = cls[1];
  assign host_data = (cls == C_IOWR) || (cls == C_DMARD);
  assign fix_wait  = (cls == C_IORD)  ? WW'(IO_RD_WAIT)  :
                     (cls == C_IOWR)  ? WW'(IO_WR_WAIT)  :
                     (cls == C_DMARD) ? WW'(DMA_RD_WAIT) : WW'(DMA_WR_WAIT);
  assign busy_eff  = !is_dma && be_busy;
  assign in_sync   = (st == S_SYNC);
  assign timeout   = in_sync && (wcnt == WW'(LONG_WAIT));
  assign ready     = in_sync && (((wcnt >= fix_wait) && !busy_eff) || timeout);
  assign fire      = ready && !timeout;
  assign sync_nib  = !ready ? (is_dma ? 4'b0101 : 4'b0110)
                            : ((timeout || be_err) ? 4'b1010 : 4'b0000);
  assign adr_next  = {adr[11:0], lad_in};
  assign hit       = (adr_next[15:AW] == io_base[15:AW]);

  assign io_rd    = fire && (cls == C_IORD);
  assign io_wr    = fire && (cls == C_IOWR);
  assign dma_put  = fire && (cls == C_DMARD);
  assign dma_get  = fire && (cls == C_DMAWR);
  assign acc_addr = adr[AW-1:0];
  assign wr_data  = dat;

  always_comb begin
    lad_oe  = 1'b0;
    lad_out = 4'hF;
    case (st)
      S_SYNC: begin lad_oe = 1'b1; lad_out = sync_nib; end
      S_TDAT: begin lad_oe = 1'b1; lad_out = cnt[0] ? dat[7:4] : dat[3:0]; end
      S_TTAR: lad_oe = (cnt == 2'd0);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cls  <= C_IORD;
      cnt  <= '0;
      adr  <= '0;
      dat  <= '0;
      wcnt <= '0;
    end else if (!lframe_n) begin
      st  <= (lad_in == 4'h0) ? S_CT : S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_CT: begin
          cnt <= '0;
          case (lad_in)
            4'b0000: begin cls <= C_IORD;  st <= S_ADR; end
            4'b0010: begin cls <= C_IOWR;  st <= S_ADR; end
            4'b1000: begin cls <= C_DMARD; st <= S_CH;  end
            4'b1010: begin cls <= C_DMAWR; st <= S_CH;  end
            default: st <= S_IDLE;
          endcase
        end
        S_ADR: begin
          adr <= adr_next;
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            cnt <= '0;
            st  <= !hit ? S_IDLE : ((cls == C_IORD) ? S_HTAR : S_HDAT);
          end
        end
        S_CH: st <= (lad_in[2:0] == 3'(DMA_CHAN)) ? S_SZ : S_IDLE;
        S_SZ: st <= (lad_in != 4'h0) ? S_IDLE : ((cls == C_DMARD) ? S_HDAT : S_HTAR);
        S_HDAT: begin
          dat <= {lad_in, dat[7:4]};
          cnt <= cnt + 2'd1;
          if (cnt[0]) begin cnt <= '0; st <= S_HTAR; end
        end
        S_HTAR: begin
          cnt <= cnt + 2'd1;
          if (cnt[0]) begin cnt <= '0; wcnt <= '0; st <= S_SYNC; end
        end
        S_SYNC: begin
          if (ready) begin
            if (!host_data) dat <= timeout ? 8'hFF : rd_data;
            st <= host_data ? S_TTAR : S_TDAT;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        S_TDAT: begin
          cnt <= cnt + 2'd1;
          if (cnt[0]) begin cnt <= '0; st <= S_TTAR; end
        end
        S_TTAR: begin
          cnt <= cnt + 2'd1;
          if (cnt[0]) begin cnt <= '0; st <= S_IDLE; end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lpc_io_dma_target_chk.sv
module lpc_io_dma_target_chk #(
  parameter int LONG_WAIT = 330
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lframe_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       in_sync,
  input logic       io_rd,
  input logic       io_wr,
  input logic       dma_put,
  input logic       dma_get
);
  logic any_strobe;
  logic seen_rst = 1'b0;
  int   wait_run;

  assign any_strobe = io_rd || io_wr || dma_put || dma_get;

  always_ff @(posedge clk) if (!rst_n) seen_rst <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_run <= 0;
    else if (in_sync && lad_oe && (lad_out == 4'b0101 || lad_out == 4'b0110)) wait_run <= wait_run + 1;
    else wait_run <= 0;
  end

  always @(negedge clk) begin
    if (!rst_n && seen_rst) begin
      p_reset_quiet_r8: assert (!lad_oe && !any_strobe);
    end
  end

  p_release_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> !lad_oe);

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_rd, io_wr, dma_put, dma_get}));

  p_wait_code_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && $past(in_sync) && (lad_out == 4'b0101 || lad_out == 4'b0110) &&
     ($past(lad_out) == 4'b0101 || $past(lad_out) == 4'b0110)) |-> lad_out == $past(lad_out));

  p_long_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_run <= LONG_WAIT);

  p_strobe_on_completion_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> (lad_oe && (lad_out == 4'b0000 || lad_out == 4'b1010)));

  p_ones_before_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lad_oe) && $past(lframe_n)) |-> $past(lad_out) == 4'hF);
endmodule

bind lpc_io_dma_target lpc_io_dma_target_chk #(.LONG_WAIT(LONG_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
  .in_sync(in_sync), .io_rd(io_rd), .io_wr(io_wr), .dma_put(dma_put), .dma_get(dma_get)
);

// File: tb/test_lpc_io_dma_target.sv
module test_lpc_io_dma_target;
  localparam int AW = 4;
  localparam int LONG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lframe_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic lad_oe;
  logic [15:0] io_base = 16'h02E0;
  logic [AW-1:0] acc_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic io_rd, io_wr, dma_put, dma_get;
  logic be_busy = 1'b0;
  logic be_err = 1'b0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpc_io_dma_target #(.AW(AW), .DMA_CHAN(3), .LONG_WAIT(LONG)) i_lpc_io_dma_target (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in), .lad_out(lad_out),
    .lad_oe(lad_oe), .io_base(io_base), .acc_addr(acc_addr), .wr_data(wr_data),
    .rd_data(rd_data), .io_rd(io_rd), .io_wr(io_wr), .dma_put(dma_put), .dma_get(dma_get),
    .be_busy(be_busy), .be_err(be_err)
  );

  // {ct, addr-or-{chan,size,..}, wdata, rdata, busy, err, claim}
  localparam int NV = 15;
  localparam logic [45:0] VEC [NV] = '{
    {4'h0, 16'h02E5, 8'h00, 8'h3C, 8'd0,  1'b0, 1'b1},  // R5 I/O read
    {4'h2, 16'h02EA, 8'h96, 8'h00, 8'd0,  1'b0, 1'b1},  // R5 I/O write
    {4'h0, 16'h02F0, 8'h00, 8'h11, 8'd0,  1'b0, 1'b0},  // R3 outside window
    {4'h2, 16'h12E1, 8'h77, 8'h00, 8'd0,  1'b0, 1'b0},  // R3 upper bits differ
    {4'h8, 16'h3000, 8'h5A, 8'h00, 8'd6,  1'b0, 1'b1},  // R5 DMA read, busy ignored
    {4'hA, 16'h3000, 8'h00, 8'hC7, 8'd0,  1'b0, 1'b1},  // R5 DMA write
    {4'h8, 16'h2000, 8'h22, 8'h00, 8'd0,  1'b0, 1'b0},  // R3 wrong channel
    {4'hA, 16'h3100, 8'h00, 8'h33, 8'd0,  1'b0, 1'b0},  // R3 size not 0000
    {4'h0, 16'h02E0, 8'h00, 8'h81, 8'd7,  1'b0, 1'b1},  // R6 busy stretch
    {4'h2, 16'h02EF, 8'hE4, 8'h00, 8'd12, 1'b0, 1'b1},  // R6 timeout at limit
    {4'h0, 16'h02E3, 8'h00, 8'h44, 8'd0,  1'b1, 1'b1},  // R7 error on read
    {4'hA, 16'hB000, 8'h00, 8'hE1, 8'd0,  1'b1, 1'b1},  // R7 error on DMA write
    {4'h4, 16'h02E1, 8'h00, 8'h00, 8'd0,  1'b0, 1'b0},  // R3 unsupported type
    {4'h0, 16'h02E9, 8'h00, 8'hD2, 8'd2,  1'b0, 1'b1},  // R6 short busy
    {4'h0, 16'h02E4, 8'h00, 8'h9E, 8'd20, 1'b0, 1'b1}   // R6 timeout on read
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic [3:0] strobes();
    return {io_rd, io_wr, dma_put, dma_get};
  endfunction

  task automatic host_nib(input logic [3:0] n, input string req);
    @(negedge clk);
    lframe_n = 1'b1;
    lad_in = n;
    #1;
    check(!lad_oe && strobes() == 4'h0, req, "target quiet in host phase", {lad_oe, strobes()}, 0);
  endtask

  task automatic run(input logic [3:0] startn, input logic [3:0] ct, input logic [15:0] a,
                     input logic [7:0] wd, input logic [7:0] rd, input int busy,
                     input bit err, input bit claim);
    bit dma = ct[3];
    bit hsend = (ct == 4'h2) || (ct == 4'h8);
    int fixw = (ct == 4'h0) ? 3 : (ct == 4'h2) ? 2 : (ct == 4'h8) ? 3 : 4;
    int bsy = dma ? 0 : busy;
    int expw = (bsy > fixw) ? bsy : fixw;
    bit to = !dma && (expw >= LONG);
    logic [3:0] wcode = dma ? 4'b0101 : 4'b0110;
    logic [3:0] fin;
    logic [3:0] exps;
    logic [7:0] got;
    int waits = 0;
    bit done = 0;
    if (to) expw = LONG;
    fin = (to || err) ? 4'b1010 : 4'b0000;
    exps = to ? 4'h0 : (ct == 4'h0) ? 4'b1000 : (ct == 4'h2) ? 4'b0100 :
                       (ct == 4'h8) ? 4'b0010 : 4'b0001;
    @(negedge clk);
    lframe_n = 1'b0; lad_in = startn; rd_data = rd; be_busy = 1'b0; be_err = 1'b0;
    host_nib(ct, "R2");
    if (!dma) begin
      host_nib(a[15:12], "R3"); host_nib(a[11:8], "R3");
      host_nib(a[7:4], "R3");   host_nib(a[3:0], "R3");
    end else begin
      host_nib(a[15:12], "R3"); host_nib(a[11:8], "R3");
    end
    if (!claim || startn != 4'h0) begin
      for (int k = 0; k < 10; k++) host_nib(4'hF, startn != 4'h0 ? "R1" : "R3");
      return;
    end
    if (hsend) begin host_nib(wd[3:0], "R9"); host_nib(wd[7:4], "R9"); end
    host_nib(4'hF, "R4"); host_nib(4'hF, "R4");
    for (int i = 0; i < LONG + 6 && !done; i++) begin
      @(negedge clk);
      lad_in = 4'hF; be_busy = (i < busy); be_err = err;
      #1;
      if (!lad_oe) begin
        check(0, "R4", "SYNC driven", 0, 1);
        done = 1;
      end else if (lad_out == 4'b0101 || lad_out == 4'b0110) begin
        check(lad_out == wcode, "R5", "wait code", lad_out, wcode);
        waits++;
      end else begin
        check(lad_out == fin, (to ? "R6" : err ? "R7" : "R4"), "completion SYNC", lad_out, fin);
        check(strobes() == exps, "R9", "strobe at completion", strobes(), exps);
        if (!dma) check(acc_addr == a[AW-1:0], "R9", "window offset", acc_addr, a[AW-1:0]);
        if (hsend && !to) check(wr_data == wd, "R9", "write byte", wr_data, wd);
        done = 1;
      end
    end
    check(waits == expw, to ? "R6" : "R5", "wait count", waits, expw);
    be_busy = 1'b0; be_err = 1'b0;
    if (!hsend) begin
      @(negedge clk); #1; got[3:0] = lad_out;
      check(lad_oe, "R7", "data nibble driven", lad_oe, 1);
      @(negedge clk); #1; got[7:4] = lad_out;
      check(got == (to ? 8'hFF : rd), to ? "R6" : "R9", "read byte low nibble first", got, to ? 8'hFF : rd);
    end
    @(negedge clk); #1;
    check(lad_oe && lad_out == 4'hF, "R10", "turnaround ones", {lad_oe, lad_out}, 5'h1F);
    @(negedge clk); #1;
    check(!lad_oe, "R10", "released", lad_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R8: frame activity under reset is ignored
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      lframe_n = (k > 1); lad_in = (k == 2) ? 4'h2 : 4'h0;
      #1;
      check(!lad_oe && strobes() == 4'h0, "R8", "quiet in reset", {lad_oe, strobes()}, 0);
    end
    @(negedge clk); lframe_n = 1'b1; lad_in = 4'hF; rst_n = 1'b1;
    @(negedge clk); #1;
    check(!lad_oe, "R8", "idle after reset", lad_oe, 0);

    for (int v = 0; v < NV; v++)
      run(4'h0, VEC[v][45:42], VEC[v][41:26], VEC[v][25:18], VEC[v][17:10],
          int'(VEC[v][9:2]), VEC[v][1], VEC[v][0]);

    // R1: non-zero frame nibble is not a start
    run(4'h3, 4'h0, 16'h02E5, 8'h00, 8'h12, 0, 1'b0, 1'b1);
    run(4'h0, 4'h0, 16'h02E6, 8'h00, 8'h5E, 0, 1'b0, 1'b1);

    // R2: abort in mid-SYNC, then a fresh cycle is decoded (first check is the release)
    @(negedge clk); lframe_n = 1'b0; lad_in = 4'h0; rd_data = 8'hAA;
    host_nib(4'h0, "R2");
    host_nib(4'h0, "R2"); host_nib(4'h2, "R2"); host_nib(4'hE, "R2"); host_nib(4'h7, "R2");
    host_nib(4'hF, "R2"); host_nib(4'hF, "R2");
    @(negedge clk); lad_in = 4'hF; #1;
    check(lad_oe && lad_out == 4'b0110, "R4", "first SYNC right after turnaround", {lad_oe, lad_out}, 5'h16);
    run(4'h0, 4'h2, 16'h02E8, 8'h3D, 8'h00, 0, 1'b0, 1'b1);

    // R1: frame held low over several clocks, last nibble is the start
    @(negedge clk); lframe_n = 1'b0; lad_in = 4'h5;
    run(4'h0, 4'h0, 16'h02E2, 8'h00, 8'h6B, 0, 1'b0, 1'b1);

    summary();
    $finish;
  end
endmodule